// File: doc/BRIEF.md
# Parallel Iterative Matching Arbiter

This block schedules cell transfers for a 4x4 input-queued switch in which every input keeps a separate queue for each output. Because the queues are split by destination, a busy output never holds back cells waiting for other outputs. Once per scheduling round the arbiter receives a request matrix: bit `in*N+out` is set when input `in` holds at least one cell for output `out`. It returns a conflict-free match matrix with the same bit layout, which tells the crossbar which input may send to which output.

A round runs up to three request-grant-accept iterations, one per clock. In each iteration, every input that is still unmatched asks every unmatched output it has cells for. Each output that receives requests grants exactly one of them. An input that receives several grants accepts exactly one. Pairs formed in earlier iterations are kept, and only the unmatched ports take part in later iterations. Grant and accept choices are pseudo-random. Each port has its own LFSR with a distinct nonzero seed, and the LFSR supplies the rotating start point of the search for a set bit. A round ends early when an iteration forms no new pair.

The control is a three-state machine. `ST_IDLE` waits for `start`, latches the request matrix and clears the match (transition *launch*). `ST_ITER` applies one iteration per cycle. It stays in place while new pairs form and fewer than three iterations have run (*iterate*), and otherwise moves to `ST_DONE` (*settle*: no new pair, or the third iteration). `ST_DONE` raises `done` for one cycle and returns to `ST_IDLE` (*release*).

Top module: `pim_match_arb`

## Requirements
- R1: A `start` seen in `ST_IDLE` captures `req_matrix`, where bit `in*4+out` set means input `in` has a cell for output `out`. Changes on `req_matrix` during a round do not affect that round's result.
- R2: Every bit set in `match_matrix` when `done` is high was also set in the captured request matrix. The bit layout is the same as in R1.
- R3: `match_matrix` never has more than one set bit in any row (input) or in any column (output).
- R4: When an iteration sees at least one request from an unmatched input to an unmatched output, that iteration forms at least one new pair. A lone request is therefore always matched.
- R5: A pair that has formed stays set for the rest of the round.
- R6: A round runs at most 3 iterations. `done` rises one cycle after the last iteration and stays high for exactly one cycle.
- R7: An iteration that forms no new pair ends the round. With an empty request matrix, `done` is high in the second cycle after the start edge. With a full permutation it is high in the third cycle. No round takes longer than the fourth cycle.
- R8: When a round ends before its third iteration, no captured request remains between an input that is still unmatched and an output that is still unmatched.
- R9: `start` is ignored while `busy` is high. It neither restarts the round nor replaces the captured requests.
- R10: After reset, `match_matrix` is zero and `busy` and `done` are low. Between rounds, `match_matrix` holds the last result.
- R11: Grant choices are pseudo-random. When the same fully contended column is requested over repeated rounds, more than one input wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scheduling round (acted on only in idle) |
| req_matrix | input | 16 | Request matrix, bit in*4+out |
| match_matrix | output | 16 | Match result, same layout as the requests |
| busy | output | 1 | Round in progress (iterating or done) |
| done | output | 1 | One-cycle pulse: match result final |

## Verification
The bench walks a table of request patterns: empty, two permutations, a lone request, a full row, a full column, a full matrix and a 2x2 block. For each pattern it checks legality, pair count and the cycle at which `done` appears. A design that let two grants through would show two bits in a row or column. One that lost early exit would report done a cycle or two late. One that gave up too soon would leave a request open between free ports.

Directed tests cover the following cases:
- A second `start` during a round. A design that honoured it would restart and pick up the new requests.
- Request changes mid-round. A design that did not latch the requests would return an empty match.
- Holding of the result between rounds.
- Random spread of winners on a contended column. A fixed-priority design would crown the same input every time.

// File: rtl/pim_pkg.sv
package pim_pkg;

    localparam int LFSR_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ITER,
        ST_DONE
    } pim_state_e;

    // Distinct nonzero seed for LFSR number k
    function automatic logic [LFSR_W-1:0] seed_for(input int k);
        logic [LFSR_W-1:0] s;
        s = 8'h5A ^ LFSR_W'(k * 29 + 3);
        if (s == '0) s = 8'h01;
        return s;
    endfunction

endpackage

// File: rtl/pim_lfsr.sv
module pim_lfsr #(
    parameter logic [pim_pkg::LFSR_W-1:0] SEED = 8'h01
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic [pim_pkg::LFSR_W-1:0] state
);
    localparam logic [pim_pkg::LFSR_W-1:0] TAPS = 8'hB8;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (state[0]) begin
            state <= (state >> 1) ^ TAPS;
        end else begin
            state <= state >> 1;
        end
    end
endmodule

// File: rtl/pim_pick.sv
module pim_pick #(
    parameter int W  = 4,
    parameter int PW = 2
) (
    input  logic [W-1:0]  vec,
    input  logic [PW-1:0] ptr,
    output logic [W-1:0]  sel
);
    // Pick the first set bit at or after the rotating pointer
    always_comb begin
        logic found;
        int   idx;
        sel   = '0;
        found = 1'b0;
        for (int k = 0; k < W; k++) begin
            idx = (int'(ptr) + k) % W;
            if (!found && vec[idx]) begin
                sel[idx] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pim_iter.sv
module pim_iter #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N*N-1:0] req_m,
    input  logic [N*N-1:0] match_m,
    input  logic [N*PW-1:0] in_ptr,
    input  logic [N*PW-1:0] out_ptr,
    output logic [N*N-1:0] accept_m
);
    logic [N-1:0]   in_free;
    logic [N-1:0]   out_free;
    logic [N*N-1:0] elig;
    logic [N*N-1:0] gnt;

    always_comb begin
        in_free  = '1;
        out_free = '1;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (match_m[i*N+j]) begin
                    in_free[i]  = 1'b0;
                    out_free[j] = 1'b0;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                elig[i*N+j] = req_m[i*N+j] & in_free[i] & out_free[j];
            end
        end
    end

    // Grant step: each output picks one requesting input
    for (genvar j = 0; j < N; j++) begin : g_out
        logic [N-1:0] col_req;
        logic [N-1:0] col_gnt;
        always_comb begin
            for (int i = 0; i < N; i++) col_req[i] = elig[i*N+j];
        end
        pim_pick #(.W(N), .PW(PW)) u_gnt (
            .vec(col_req),
            .ptr(out_ptr[j*PW +: PW]),
            .sel(col_gnt)
        );
        for (genvar i = 0; i < N; i++) begin : g_scatter
            assign gnt[i*N+j] = col_gnt[i];
        end
    end

    // Accept step: each input picks one granting output
    for (genvar i = 0; i < N; i++) begin : g_in
        logic [N-1:0] row_sel;
        pim_pick #(.W(N), .PW(PW)) u_acc (
            .vec(gnt[i*N +: N]),
            .ptr(in_ptr[i*PW +: PW]),
            .sel(row_sel)
        );
        assign accept_m[i*N +: N] = row_sel;
    end
endmodule

// File: rtl/pim_match_arb.sv
module pim_match_arb #(
    parameter int N     = 4,
    parameter int NITER = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N*N-1:0] req_matrix,
    output logic [N*N-1:0] match_matrix,
    output logic           busy,
    output logic           done
);
    import pim_pkg::*;

    localparam int PW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = $clog2(NITER + 1);

    pim_state_e     state_q, state_d;
    logic [N*N-1:0] req_q;
    logic [N*N-1:0] match_q;
    logic [CW-1:0]  iter_q;
    logic [N*N-1:0] accept_m;
    logic [N*PW-1:0] in_ptr;
    logic [N*PW-1:0] out_ptr;
    logic           new_pair;
    logic           last_iter;

    // Per-port random sources
    for (genvar k = 0; k < N; k++) begin : g_rng
        logic [LFSR_W-1:0] in_lfsr;
        logic [LFSR_W-1:0] out_lfsr;
        pim_lfsr #(.SEED(seed_for(k))) u_in_rng (
            .clk(clk), .rst_n(rst_n), .state(in_lfsr)
        );
        pim_lfsr #(.SEED(seed_for(k + N))) u_out_rng (
            .clk(clk), .rst_n(rst_n), .state(out_lfsr)
        );
        assign in_ptr[k*PW +: PW]  = in_lfsr[PW-1:0];
        assign out_ptr[k*PW +: PW] = out_lfsr[PW-1:0];
    end

    pim_iter #(.N(N), .PW(PW)) u_iter (
        .req_m(req_q),
        .match_m(match_q),
        .in_ptr(in_ptr),
        .out_ptr(out_ptr),
        .accept_m(accept_m)
    );

    assign new_pair  = |accept_m;
    assign last_iter = (iter_q == CW'(NITER - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_ITER;
            ST_ITER: if (!new_pair || last_iter) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Round datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= '0;
            match_q <= '0;
            iter_q  <= '0;
        end else if (state_q == ST_IDLE && start) begin
            req_q   <= req_matrix;
            match_q <= '0;
            iter_q  <= '0;
        end else if (state_q == ST_ITER) begin
            match_q <= match_q | accept_m;
            iter_q  <= iter_q + CW'(1);
        end
    end

    // Outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin busy = 1'b0; done = 1'b0; end
            ST_ITER: begin busy = 1'b1; done = 1'b0; end
            ST_DONE: begin busy = 1'b1; done = 1'b1; end
            default: begin busy = 1'b0; done = 1'b0; end
        endcase
    end

    assign match_matrix = match_q;
endmodule

// File: rtl/pim_match_chk.sv
module pim_match_chk #(
    parameter int N     = 4,
    parameter int NITER = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [N*N-1:0] match_m,
    input logic [N*N-1:0] req_m
);
    logic       past_ok;
    logic [7:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok  <= 1'b0;
            busy_cnt <= '0;
        end else begin
            past_ok <= 1'b1;
            if (!busy)                busy_cnt <= '0;
            else if (busy_cnt != '1)  busy_cnt <= busy_cnt + 8'd1;
        end
    end

    // R2
    subset_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((match_m & ~req_m) == '0));

    for (genvar i = 0; i < N; i++) begin : g_row
        // R3
        row_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(match_m[i*N +: N]));
    end

    for (genvar j = 0; j < N; j++) begin : g_col
        logic [N-1:0] colv;
        for (genvar i = 0; i < N; i++) begin : g_bit
            assign colv[i] = match_m[i*N+j];
        end
        // R3
        col_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(colv));
    end

    // R5
    keep_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && busy && $past(busy) |-> (($past(match_m) & ~match_m) == '0));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    round_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt >= 8'd1 && busy_cnt <= 8'(NITER)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !busy && !start |=> $stable(match_m));
endmodule

bind pim_match_arb pim_match_chk #(.N(N), .NITER(NITER)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .start(start),
    .busy(busy),
    .done(done),
    .match_m(match_matrix),
    .req_m(req_q)
);

// File: tb/test_pim_match_arb.sv
`timescale 1ns/1ps
module test_pim_match_arb;
    localparam int N  = 4;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] req_matrix = '0;
    logic [15:0] match_matrix;
    logic        busy;
    logic        done;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pim_match_arb #(.N(N), .NITER(3)) i_pim_match_arb (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_matrix(req_matrix), .match_matrix(match_matrix),
        .busy(busy), .done(done)
    );

    // Vector table: request, expected pair count (-1 = any), expected latency (0 = any)
    localparam logic [15:0] V_REQ [NV] = '{16'h0000, 16'h8421, 16'h1248, 16'h0040,
                                           16'h00F0, 16'h4444, 16'hFFFF, 16'h0033};
    localparam int V_CNT [NV] = '{0, 4, 4, 1, 1, 1, -1, 2};
    localparam int V_LAT [NV] = '{2, 3, 3, 3, 3, 3, 0, 0};

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic int popc(input logic [15:0] v);
        int c = 0;
        for (int b = 0; b < 16; b++) c += int'(v[b]);
        return c;
    endfunction

    function automatic bit lines_ok(input logic [15:0] m);
        for (int i = 0; i < N; i++) begin
            int r = 0;
            int c = 0;
            for (int j = 0; j < N; j++) begin
                r += int'(m[i*N+j]);
                c += int'(m[j*N+i]);
            end
            if (r > 1 || c > 1) return 0;
        end
        return 1;
    endfunction

    function automatic bit maximal(input logic [15:0] r, input logic [15:0] m);
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (r[i*N+j] && (m[i*N +: N] == '0)) begin
                    bit col_free = 1;
                    for (int k = 0; k < N; k++) if (m[k*N+j]) col_free = 0;
                    if (col_free) return 0;
                end
            end
        end
        return 1;
    endfunction

    // Start a round at a negedge; return match and negedges until done
    task automatic run_round(input logic [15:0] r, output logic [15:0] m, output int lat);
        req_matrix = r;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        m = match_matrix;
        @(negedge clk);
        check(!done, "R6", "done pulse width", 32'(done), 0);
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] m;
        logic [15:0] keep;
        int          lat;
        logic [3:0]  winners;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(match_matrix == 0, "R10", "match after reset", 32'(match_matrix), 0);
        check(!busy && !done, "R10", "busy/done after reset", {busy, done}, 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            run_round(V_REQ[v], m, lat);
            check((m & ~V_REQ[v]) == 0, "R2", "only requested pairs", 32'(m), 32'(m & V_REQ[v]));
            check(lines_ok(m), "R3", "one per row/column", 32'(m), 0);
            check(lat >= 2 && lat <= 4, "R6", "round length", 32'(lat), 4);
            if (V_CNT[v] >= 0)
                check(popc(m) == V_CNT[v], "R4", "pair count", 32'(popc(m)), 32'(V_CNT[v]));
            if (V_LAT[v] > 0)
                check(lat == V_LAT[v], "R7", "early end latency", 32'(lat), 32'(V_LAT[v]));
            if (lat < 4)
                check(maximal(V_REQ[v], m), "R8", "maximal on early end", 32'(m), 32'(V_REQ[v]));
        end

        // R10 hold between rounds
        run_round(16'h8421, keep, lat);
        req_matrix = 16'hFFFF;
        repeat (4) @(negedge clk);
        check(match_matrix == keep, "R10", "result held in idle", 32'(match_matrix), 32'(keep));

        // R1 request change mid-round ignored
        req_matrix = 16'h1248;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        req_matrix = 16'h0000;
        while (!done) @(negedge clk);
        check(match_matrix == 16'h1248, "R1", "captured requests used", 32'(match_matrix), 32'h1248);
        @(negedge clk);

        // R9 start while busy ignored
        req_matrix = 16'h0040;
        start = 1'b1;
        @(negedge clk);
        lat = 1;
        req_matrix = 16'hFFFF;
        while (!done) begin
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(match_matrix == 16'h0040, "R9", "busy start ignored (match)", 32'(match_matrix), 32'h0040);
        check(lat == 3, "R9", "busy start ignored (latency)", 32'(lat), 3);
        repeat (2) @(negedge clk);
        check(!busy, "R9", "idle after round", 32'(busy), 0);

        // R11 random winners on a contended column (all inputs want output 0)
        winners = '0;
        for (int r = 0; r < 12; r++) begin
            run_round(16'h1111, m, lat);
            for (int i = 0; i < N; i++) if (m[i*N]) winners[i] = 1'b1;
            repeat (r % 3) @(negedge clk);
        end
        check(popc({12'h0, winners}) >= 2, "R11", "distinct winners", 32'(winners), 32'hF);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule